// File: doc/BRIEF.md
# Block-buffered halfword DMA channel

This channel moves halfword data between a 16-bit streaming peripheral port and memory, always in whole 64-byte blocks. A 32-entry halfword buffer sits between the two sides. Software loads an aligned block base address and a block count, then starts the channel in one of two directions. A 6-bit byte pointer picks the halfword slot inside the current block. It always holds an even value.

Misaligned transfers are handled through that pointer. To write into memory from a misaligned start, software first pushes the leading halfwords of the original memory block into the buffer. Each push advances the pointer, so peripheral data lands after those halfwords and the first block written back keeps them unchanged. To read from memory from a misaligned start, software pops halfwords before starting, and draining to the peripheral begins at the pointer.

When a peripheral-to-memory run is halted before a block fills, the partial block stays in the buffer. The pointer then tells how many bytes are held, and the base register holds the address they belong to. Software reads that tail back through the data register.

Top module: `dma_blk_top`

## Requirements
- R1: After reset, all registers read zero: control (offset 0), base (offset 1), count (offset 2) and pointer (offset 3). `mem_req`, `in_ready`, `out_valid` and `xfer_done` are low.
- R2: A write to offset 1 stores the address with its low six bits cleared. Reading offset 1 returns the current block address.
- R3: While the channel is idle, a write to offset 4 stores the low halfword at the pointer slot and advances the pointer by 2, wrapping from 62 to 0. A read of offset 4 returns the halfword at the pointer and advances it by 2. A write to offset 3 keeps only bits 5:1, so the stored pointer is always even.
- R4: A control write with bit 0 = 1 starts the channel, and bit 1 = 1 selects peripheral-to-memory. Peripheral words then fill the buffer from the pointer slot. When slot 31 fills, 32 write beats go out, beat i carrying slot i to address base + 2*i. Slots pushed earlier by software are written unchanged.
- R5: Each completed 64-byte memory block adds 64 to the base and subtracts 1 from the count. When the count reaches zero, the channel goes idle, raises `xfer_done` and drops `in_ready`.
- R6: Holding `halt` during a peripheral fill ends the run with `xfer_done`. The partial block stays in the buffer, the pointer equals the byte count held, and the base register gives the block address for that tail.
- R7: Starting with bit 1 = 0 (memory-to-peripheral) reads 32 beats from base + 2*i into slot i. The buffer is then presented on `out_data` from the pointer slot onward, and later blocks are presented from slot 0. A presented word stays stable until it is accepted.
- R8: `halt` during memory-to-peripheral draining ends the run with `xfer_done`, and no further word is offered.
- R9: A start with a count of zero raises `xfer_done` at once and issues no memory request.
- R10: While the channel is busy, writes to the base, count, pointer and data registers, and reads of the data register, have no effect.
- R11: A memory request keeps its address and direction unchanged until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (pops the buffer at offset 4) |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, combinational |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | 16 | Write beat data |
| mem_rdata | input | 16 | Read beat data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat accepted |
| in_valid | input | 1 | Peripheral word offered |
| in_data | input | 16 | Peripheral word |
| in_ready | output | 1 | Channel takes the offered word |
| out_valid | output | 1 | Word offered to the peripheral |
| out_data | output | 16 | Word to the peripheral |
| out_ready | input | 1 | Peripheral takes the word |
| halt | input | 1 | Ends the run early |
| xfer_done | output | 1 | Run finished; cleared by the next start |

## Verification
A pointer that slips by one slot shows up in the very first memory block as a rotated or duplicated halfword next to the software-pushed head. It also appears as a wrong consumed-word count when the run ends. A base or count that steps at the wrong moment shows up as the last block landing at the wrong address, or as the run ending one block early or late, within one block time. The halt cases expose a lost or overwritten tail directly: the pointer and the data read back after the halt are wrong.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;

    localparam int unsigned HW_W      = 16;
    localparam int unsigned BLK_BYTES = 64;
    localparam int unsigned HW_BYTES  = HW_W / 8;
    localparam int unsigned ENTRIES   = BLK_BYTES / HW_BYTES;
    localparam int unsigned IDX_W     = $clog2(ENTRIES);
    localparam int unsigned OFS_W     = $clog2(BLK_BYTES);
    localparam int unsigned SEL_W     = 3;

    typedef enum logic [SEL_W-1:0] {
        RS_CTRL  = 3'd0,
        RS_BASE  = 3'd1,
        RS_COUNT = 3'd2,
        RS_PTR   = 3'd3,
        RS_DATA  = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_FLUSH,
        ST_LOAD,
        ST_DRAIN
    } chan_st_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [HW_W-1:0]  data;
    } buf_wr_t;

    function automatic logic [63:0] blk_floor(input logic [63:0] a);
        return a & ~64'(BLK_BYTES - 1);
    endfunction

endpackage

// File: rtl/dma_blk_buf.sv
module dma_blk_buf
    import dma_blk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  buf_wr_t          wr,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [HW_W-1:0]  ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [HW_W-1:0]  rb_data
);

    logic [HW_W-1:0] slot_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(ENTRIES); i++) slot_q[i] <= '0;
        end else if (wr.en) begin
            slot_q[wr.idx] <= wr.data;
        end
    end

    assign ra_data = slot_q[ra_idx];
    assign rb_data = slot_q[rb_idx];

endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
    import dma_blk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_p2m,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              ptr_wr,
    input  logic [OFS_W-1:0]  ptr_val,
    input  logic              cpu_push,
    input  logic              cpu_pop,
    input  logic [HW_W-1:0]   cpu_data,
    input  logic              halt,
    input  logic              in_valid,
    input  logic [HW_W-1:0]   in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [HW_W-1:0]   mem_rdata,
    input  logic [HW_W-1:0]   ra_data,
    output buf_wr_t           buf_wr,
    output logic [IDX_W-1:0]  ra_idx,
    output logic [IDX_W-1:0]  rb_idx,
    output logic [OFS_W-1:0]  ptr_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              busy,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
    localparam logic [ADDR_W-1:0] BLK_STEP = ADDR_W'(BLK_BYTES);

    chan_st_e          st_q;
    logic [IDX_W-1:0]  pidx_q;
    logic [IDX_W-1:0]  beat_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              halt_pend_q;

    wire fill_take  = (st_q == ST_FILL) && in_valid && !halt;
    wire drain_take = out_valid && out_ready;
    wire idle       = (st_q == ST_IDLE);

    always_comb begin
        in_ready  = (st_q == ST_FILL) && !halt;
        out_valid = (st_q == ST_DRAIN) && !halt && !halt_pend_q;
        mem_req   = (st_q == ST_FLUSH) || (st_q == ST_LOAD);
        mem_we    = (st_q == ST_FLUSH);
        mem_addr  = base_q + ADDR_W'({beat_q, 1'b0});
        ra_idx    = pidx_q;
        rb_idx    = beat_q;
        buf_wr    = '0;
        if (idle && cpu_push) begin
            buf_wr.en   = 1'b1;
            buf_wr.idx  = pidx_q;
            buf_wr.data = cpu_data;
        end else if (fill_take) begin
            buf_wr.en   = 1'b1;
            buf_wr.idx  = pidx_q;
            buf_wr.data = in_data;
        end else if ((st_q == ST_LOAD) && mem_ack) begin
            buf_wr.en   = 1'b1;
            buf_wr.idx  = beat_q;
            buf_wr.data = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            pidx_q      <= '0;
            beat_q      <= '0;
            base_q      <= '0;
            cnt_q       <= '0;
            done_q      <= 1'b0;
            halt_pend_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (base_wr) base_q <= ADDR_W'(blk_floor(64'(base_val)));
                    if (cnt_wr) cnt_q <= cnt_val;
                    if (ptr_wr) pidx_q <= ptr_val[OFS_W-1:1];
                    else if (cpu_push || cpu_pop) pidx_q <= pidx_q + 1'b1;
                    if (start) begin
                        halt_pend_q <= 1'b0;
                        beat_q      <= '0;
                        if (cnt_q == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q <= 1'b0;
                            st_q   <= start_p2m ? ST_FILL : ST_LOAD;
                        end
                    end
                end
                ST_FILL: begin
                    if (halt) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else if (fill_take) begin
                        pidx_q <= pidx_q + 1'b1;
                        if (pidx_q == LAST) begin
                            st_q   <= ST_FLUSH;
                            beat_q <= '0;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (halt) halt_pend_q <= 1'b1;
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST) begin
                            base_q <= base_q + BLK_STEP;
                            cnt_q  <= cnt_q - 1'b1;
                            if (cnt_q == CNT_W'(1) || halt_pend_q || halt) begin
                                st_q   <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                st_q <= ST_FILL;
                            end
                        end
                    end
                end
                ST_LOAD: begin
                    if (halt) halt_pend_q <= 1'b1;
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST) begin
                            cnt_q <= cnt_q - 1'b1;
                            if (halt_pend_q || halt) begin
                                st_q   <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                st_q <= ST_DRAIN;
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    if (halt || halt_pend_q) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else if (drain_take) begin
                        pidx_q <= pidx_q + 1'b1;
                        if (pidx_q == LAST) begin
                            base_q <= base_q + BLK_STEP;
                            beat_q <= '0;
                            if (cnt_q == '0) begin
                                st_q   <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                st_q <= ST_LOAD;
                            end
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign ptr_o  = {pidx_q, 1'b0};
    assign base_o = base_q;
    assign cnt_o  = cnt_q;
    assign busy   = !idle;
    assign done   = done_q;

    // R11: a pending beat holds its address and direction
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R7: an offered word not taken stays unchanged
    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !halt) |=> $stable(ra_data));

    // R5: the finished flag is only seen while idle
    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (st_q == ST_IDLE));

    // R4: a block write-out always follows a completely filled buffer
    p_flush_full_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FLUSH) |-> (pidx_q == '0));

    // R9: a start with zero count never leaves idle
    p_zero_start_r9: assert property (@(posedge clk) disable iff (rst)
        (idle && start && cnt_q == '0 && !cnt_wr) |=> !mem_req && !in_ready);

endmodule

// File: rtl/dma_blk_top.sv
module dma_blk_top
    import dma_blk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned CPU_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [2:0]        cpu_addr,
    input  logic [CPU_W-1:0]  cpu_wdata,
    output logic [CPU_W-1:0]  cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              in_valid,
    input  logic [15:0]       in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [15:0]       out_data,
    input  logic              out_ready,
    input  logic              halt,
    output logic              xfer_done
);

    reg_sel_e          sel;
    logic              busy;
    logic              dir_q;
    logic [OFS_W-1:0]  ptr_cur;
    logic [ADDR_W-1:0] base_cur;
    logic [CNT_W-1:0]  cnt_cur;
    logic [HW_W-1:0]   ra_data;
    logic [HW_W-1:0]   rb_data;
    logic [IDX_W-1:0]  ra_idx;
    logic [IDX_W-1:0]  rb_idx;
    buf_wr_t           buf_wr;

    assign sel = reg_sel_e'(cpu_addr);

    wire wr_ok   = cpu_wr && !busy;
    wire do_strt = wr_ok && (sel == RS_CTRL) && cpu_wdata[0];
    wire do_base = wr_ok && (sel == RS_BASE);
    wire do_cnt  = wr_ok && (sel == RS_COUNT);
    wire do_ptr  = wr_ok && (sel == RS_PTR);
    wire do_push = wr_ok && (sel == RS_DATA);
    wire do_pop  = cpu_rd && !busy && (sel == RS_DATA);

    always_ff @(posedge clk) begin
        if (rst) dir_q <= 1'b0;
        else if (wr_ok && sel == RS_CTRL) dir_q <= cpu_wdata[1];
    end

    always_comb begin
        unique case (sel)
            RS_CTRL:  cpu_rdata = CPU_W'({dir_q, xfer_done, busy});
            RS_BASE:  cpu_rdata = CPU_W'(base_cur);
            RS_COUNT: cpu_rdata = CPU_W'(cnt_cur);
            RS_PTR:   cpu_rdata = CPU_W'(ptr_cur);
            RS_DATA:  cpu_rdata = CPU_W'(ra_data);
            default:  cpu_rdata = '0;
        endcase
    end

    dma_blk_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr      (buf_wr),
        .ra_idx  (ra_idx),
        .ra_data (ra_data),
        .rb_idx  (rb_idx),
        .rb_data (rb_data)
    );

    dma_blk_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (do_strt),
        .start_p2m (cpu_wdata[1]),
        .base_wr   (do_base),
        .base_val  (cpu_wdata[ADDR_W-1:0]),
        .cnt_wr    (do_cnt),
        .cnt_val   (cpu_wdata[CNT_W-1:0]),
        .ptr_wr    (do_ptr),
        .ptr_val   (cpu_wdata[OFS_W-1:0]),
        .cpu_push  (do_push),
        .cpu_pop   (do_pop),
        .cpu_data  (cpu_wdata[HW_W-1:0]),
        .halt      (halt),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .ra_data   (ra_data),
        .buf_wr    (buf_wr),
        .ra_idx    (ra_idx),
        .rb_idx    (rb_idx),
        .ptr_o     (ptr_cur),
        .base_o    (base_cur),
        .cnt_o     (cnt_cur),
        .busy      (busy),
        .done      (xfer_done)
    );

    assign mem_wdata = rb_data;
    assign out_data  = ra_data;

    // R3: the pointer reported to software is always halfword aligned
    p_ptr_even_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && sel == RS_PTR) |-> (cpu_rdata[0] == 1'b0));

    // R10: a data push while busy leaves the pointer where it was
    p_busy_push_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && busy && sel == RS_DATA && !in_ready && !out_valid) |=> $stable(ptr_cur));

endmodule

// File: tb/dma_blk_tb.sv
module dma_blk_top_tb_top;

    localparam int A_BASE = 1, A_CNT = 2, A_PTR = 3, A_DATA = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic        in_valid = 1'b0, in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid, out_ready = 1'b0;
    logic [15:0] out_data;
    logic        halt = 1'b0;
    logic        xfer_done;

    int n_cmp = 0, n_bad = 0;
    int mem_lat = 0, sink_pat = 0;
    int src_on = 0, src_idx = 0, src_limit = 0;
    int sink_on = 0, rcv_n = 0, sink_limit = 0;
    int req_seen = 0, cyc = 0;
    logic [15:0] bmem [0:4095];
    logic [15:0] rcv [0:127];

    always #10 clk = ~clk;

    dma_blk_top dut_i (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .halt(halt), .xfer_done(xfer_done)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model, peripheral source and sink, all driven at the falling edge
    always begin
        @(negedge clk);
        cyc++;
        mem_ack   = mem_req && (mem_lat == 0 || cyc[0]);
        mem_rdata = bmem[mem_addr[12:1]];
        in_valid  = (src_on != 0) && (src_idx < src_limit);
        in_data   = 16'h1000 + 16'(src_idx);
        out_ready = (sink_on != 0) && (rcv_n < sink_limit) && (sink_pat == 0 || cyc[1]);
        #9;
        if (mem_req) req_seen++;
        if (mem_req && mem_ack && mem_we) bmem[mem_addr[12:1]] = mem_wdata;
        if (in_valid && in_ready) src_idx++;
        if (out_valid && out_ready) begin
            rcv[rcv_n] = out_data;
            rcv_n++;
        end
    end

    always begin
        @(posedge clk);
        if (cyc > 190000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    task automatic cpu_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 3'(a); cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input int a, output logic [31:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 3'(a);
        #2 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!xfer_done && n < 6000) begin
            @(negedge clk);
            n++;
        end
        chk(req, 32'(xfer_done), 32'd1);
    endtask

    task automatic pulse_halt();
        @(negedge clk); halt = 1'b1;
        @(negedge clk); halt = 1'b0;
    endtask

    task automatic run_p2m(input int k);
        logic [31:0] d;
        int e0 = 0, e1 = 0;
        for (int i = 0; i < 64; i++) bmem[512 + i] = 16'hFFFF;
        src_idx = 0; src_limit = 1000;
        cpu_write(A_PTR, 0);
        for (int j = 0; j < k / 2; j++) cpu_write(A_DATA, 32'h5000 + 32'(j));
        cpu_write(A_BASE, 32'h400 + 32'(k));
        cpu_write(A_CNT, 2);
        src_on = 1;
        cpu_write(0, 3);
        wait_done("R5 p2m finish");
        src_on = 0;
        for (int i = 0; i < 32; i++) begin
            if (bmem[512 + i] !== ((i < k / 2) ? 16'h5000 + 16'(i) : 16'h1000 + 16'(i - k / 2))) e0++;
            if (bmem[544 + i] !== 16'h1000 + 16'(32 - k / 2 + i)) e1++;
        end
        chk("R4 first block merge", 32'(e0), 0);
        chk("R4 second block", 32'(e1), 0);
        chk("R4 words consumed", 32'(src_idx), 32'(64 - k / 2));
        cpu_read(A_BASE, d); chk("R5 base advanced", d, 32'h480);
        cpu_read(A_CNT, d);  chk("R5 count zero", d, 0);
        chk("R5 in_ready low", 32'(in_ready), 0);
    endtask

    task automatic run_m2p(input int k);
        logic [31:0] d;
        int e = 0;
        for (int i = 0; i < 64; i++) bmem[1536 + i] = 16'h7000 + 16'(i);
        cpu_write(A_PTR, 0);
        for (int j = 0; j < k / 2; j++) cpu_read(A_DATA, d);
        cpu_read(A_PTR, d); chk("R3 pops move pointer", d, 32'(k));
        cpu_write(A_BASE, 32'hC00);
        cpu_write(A_CNT, 2);
        rcv_n = 0; sink_limit = 1000; sink_on = 1;
        cpu_write(0, 1);
        wait_done("R7 m2p finish");
        sink_on = 0;
        chk("R7 words delivered", 32'(rcv_n), 32'(64 - k / 2));
        for (int n = 0; n < 64 - k / 2; n++)
            if (rcv[n] !== 16'h7000 + 16'(k / 2 + n)) e++;
        chk("R7 delivered order", 32'(e), 0);
        cpu_read(A_BASE, d); chk("R5 m2p base", d, 32'hC80);
    endtask

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 4096; i++) bmem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            cpu_read(a, d); chk("R1 register zero", d, 0);
        end
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 in_ready", 32'(in_ready), 0);
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 xfer_done", 32'(xfer_done), 0);

        // R2 base truncation
        cpu_write(A_BASE, 32'h1234);     cpu_read(A_BASE, d); chk("R2 base", d, 32'h1200);
        cpu_write(A_BASE, 32'hFFFFFFFF); cpu_read(A_BASE, d); chk("R2 base", d, 32'hFFFFFFC0);
        cpu_write(A_BASE, 32'h40);       cpu_read(A_BASE, d); chk("R2 base", d, 32'h40);

        // R3 push / pop sweep over all slots
        cpu_write(A_PTR, 0);
        for (int i = 0; i < 32; i++) cpu_write(A_DATA, 32'hA000 + 32'(i));
        cpu_read(A_PTR, d); chk("R3 pointer wrap", d, 0);
        for (int i = 0; i < 32; i++) begin
            cpu_read(A_DATA, d); chk("R3 pop value", d, 32'hA000 + 32'(i));
        end
        cpu_write(A_PTR, 5); cpu_read(A_PTR, d); chk("R3 pointer even", d, 4);

        // R4 R5 peripheral to memory, offset and latency sweep
        for (int m = 0; m < 2; m++) begin
            mem_lat = m;
            run_p2m(0); run_p2m(2); run_p2m(30); run_p2m(62);
        end

        // R7 memory to peripheral, offset and backpressure sweep
        for (int m = 0; m < 2; m++) begin
            mem_lat = m; sink_pat = m;
            run_m2p(0); run_m2p(2); run_m2p(40); run_m2p(62);
        end

        // R6 halt during fill, with R10 busy writes
        mem_lat = 1;
        for (int i = 0; i < 64; i++) bmem[1024 + i] = 16'hFFFF;
        src_idx = 0; src_limit = 37;
        cpu_write(A_PTR, 0);
        cpu_write(A_BASE, 32'h800);
        cpu_write(A_CNT, 3);
        src_on = 1;
        cpu_write(0, 3);
        repeat (300) @(negedge clk);
        cpu_read(0, d); chk("R6 still busy", d & 1, 1);
        cpu_write(A_BASE, 0); cpu_write(A_CNT, 99); cpu_write(A_PTR, 0);
        cpu_write(A_DATA, 32'hDEAD); cpu_read(A_DATA, d);
        cpu_read(A_BASE, d); chk("R10 base kept", d, 32'h840);
        cpu_read(A_CNT, d);  chk("R10 count kept", d, 2);
        cpu_read(A_PTR, d);  chk("R10 pointer kept", d, 10);
        pulse_halt();
        src_on = 0;
        chk("R6 done after halt", 32'(xfer_done), 1);
        chk("R6 in_ready low", 32'(in_ready), 0);
        cpu_read(A_PTR, d);  chk("R6 tail bytes", d, 10);
        cpu_read(A_BASE, d); chk("R6 tail address", d, 32'h840);
        begin
            int e = 0;
            for (int i = 0; i < 32; i++) if (bmem[1024 + i] !== 16'h1000 + 16'(i)) e++;
            chk("R4 block before halt", 32'(e), 0);
            e = 0;
            for (int i = 0; i < 32; i++) if (bmem[1056 + i] !== 16'hFFFF) e++;
            chk("R6 tail not written", 32'(e), 0);
        end
        cpu_write(A_PTR, 0);
        for (int j = 0; j < 5; j++) begin
            cpu_read(A_DATA, d); chk("R6 tail data", d, 32'h1000 + 32'(32 + j));
        end

        // R8 halt during drain
        sink_pat = 0;
        cpu_write(A_PTR, 0);
        cpu_write(A_BASE, 32'hC00);
        cpu_write(A_CNT, 2);
        rcv_n = 0; sink_limit = 10; sink_on = 1;
        cpu_write(0, 1);
        repeat (150) @(negedge clk);
        cpu_read(0, d); chk("R8 busy before halt", d & 1, 1);
        pulse_halt();
        sink_limit = 1000;
        repeat (5) @(negedge clk);
        chk("R8 done", 32'(xfer_done), 1);
        chk("R8 no offer", 32'(out_valid), 0);
        chk("R8 words taken", 32'(rcv_n), 10);
        cpu_read(A_CNT, d); chk("R8 count", d, 1);
        sink_on = 0;

        // R9 zero count start
        cpu_write(A_CNT, 0);
        req_seen = 0;
        cpu_write(0, 3);
        chk("R9 done at once", 32'(xfer_done), 1);
        repeat (20) @(negedge clk);
        chk("R9 no memory request", 32'(req_seen), 0);
        cpu_read(0, d); chk("R9 idle", d & 1, 0);

        summary();
        $finish;
    end

endmodule